// File: doc/BRIEF.md
# Vendor Control Request Register Decoder

This block sits behind the control endpoint of a USB-to-serial bridge. It sees the setup stage of each control transfer as a request-type byte, a request code and a length, and then, for host-to-device transfers, the data stage as a stream of payload bytes. It turns these transfers into writes and reads of the serial port's configuration and status registers. These registers are the line control byte, the modem control byte, a 32-bit baud divisor and a flag that holds transmission until the far end asserts CTS.

Each accepted request ends in a one-cycle acknowledge pulse. A read request returns its byte together with that pulse. A request the block does not know, or one with the wrong length for its code, ends in a one-cycle stall pulse and leaves every register as it was. A new setup that arrives while a payload is still being collected cancels the unfinished write, so a short payload never reaches a register. The block also tracks the four modem status lines and keeps sticky change flags for the host to read.

Top module: `vreq_decoder`

## Requirements
- R1: After reset the line control output is 0x03, the modem control output is 0x08, the divisor is 12, the CTS hold flag is 1, and ack, stall and read-valid are low.
- R2: A request-type byte of 0x40 selects host-to-device and 0xC0 selects device-to-host. Any other type value, or a code not listed for that direction, gives a stall pulse in the cycle after the setup strobe, with no register change.
- R3: Host-to-device code 5 with length 4 loads the divisor little-endian: the first payload byte goes to bits 7:0 and the fourth to bits 31:24. The divisor and ack change together at the clock edge that takes the fourth byte.
- R4: A setup strobe that arrives before the fourth divisor byte cancels the write and the divisor keeps its old value.
- R5: Host-to-device code 7 (length 1) sets the line control byte. Device-to-host code 6 (length 1) returns it.
- R6: Host-to-device code 10 (length 1) sets the modem control byte, which becomes visible with ack at the edge that takes the byte.
- R7: Device-to-host code 2 (length 1) returns the modem status byte as {cd, ri, dsr, cts, cd changed, ri fell, dsr changed, cts changed}, from modem_i = {cd, ri, dsr, cts}. Each change flag is sticky and is cleared by the read that returns it. A rising ri sets no flag.
- R8: Host-to-device code 12 (length 1) clears the CTS hold flag for a zero byte and sets it for any nonzero byte. tx_enable_o is high when the flag is clear or cts is high.
- R9: Host-to-device code 11 (length 1) is acknowledged and changes no register.
- R10: A known code with a length other than its own (4 for code 5, 1 for all others) gives a stall pulse and changes no register.
- R11: A read request gives rd_valid_o and ack_o together, for one cycle, in the cycle after the setup strobe.
- R12: Payload bytes presented while no write is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | Setup stage strobe, one cycle |
| req_type_i | input | 8 | Request-type byte |
| req_code_i | input | 8 | Request code |
| req_len_i | input | 16 | Data stage length in bytes |
| data_valid_i | input | 1 | Payload byte strobe |
| data_i | input | 8 | Payload byte |
| modem_i | input | 4 | Modem status lines {cd, ri, dsr, cts} |
| ack_o | output | 1 | Request completed |
| stall_o | output | 1 | Request rejected |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data byte |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| divisor_o | output | 32 | Baud divisor |
| cts_hold_o | output | 1 | Hold transmission until CTS |
| tx_enable_o | output | 1 | Transmission permitted |

## Verification
The assertions check on every cycle that ack and stall never coincide, that every read response carries an ack, and that no configuration register moves except in a cycle with an ack. They also check that a stall leaves all configuration registers unchanged. The bench scenarios are needed for the values themselves: the little-endian byte order of the divisor, the abort of a short divisor payload, the exact bytes returned for line control and modem status, the sticky and clear-on-read behaviour of the change flags, and the CTS gating of tx_enable_o.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
  localparam logic [7:0] TYPE_WR = 8'h40;
  localparam logic [7:0] TYPE_RD = 8'hC0;

  localparam logic [7:0] CODE_MSR_RD = 8'd2;
  localparam logic [7:0] CODE_DIV_WR = 8'd5;
  localparam logic [7:0] CODE_LCR_RD = 8'd6;
  localparam logic [7:0] CODE_LCR_WR = 8'd7;
  localparam logic [7:0] CODE_MCR_WR = 8'd10;
  localparam logic [7:0] CODE_NOP_WR = 8'd11;
  localparam logic [7:0] CODE_CTS_WR = 8'd12;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DIV_W,
    OP_LCR_W,
    OP_MCR_W,
    OP_NOP_W,
    OP_CTS_W,
    OP_LCR_R,
    OP_MSR_R
  } op_e;

  function automatic logic op_is_write(op_e op);
    return (op == OP_DIV_W) || (op == OP_LCR_W) || (op == OP_MCR_W) ||
           (op == OP_NOP_W) || (op == OP_CTS_W);
  endfunction
endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
  import vreq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int DIV_BYTES = 4,
  localparam int CNT_W    = $clog2(DIV_BYTES + 1)
) (
  input  logic [7:0]       type_i,
  input  logic [7:0]       code_i,
  input  logic [LEN_W-1:0] len_i,
  output op_e              op_o,
  output logic [CNT_W-1:0] nbytes_o
);
  op_e              op_raw;
  logic [LEN_W-1:0] need_len;

  always_comb begin
    op_raw = OP_NONE;
    if (type_i == TYPE_WR) begin
      unique case (code_i)
        CODE_DIV_WR: op_raw = OP_DIV_W;
        CODE_LCR_WR: op_raw = OP_LCR_W;
        CODE_MCR_WR: op_raw = OP_MCR_W;
        CODE_NOP_WR: op_raw = OP_NOP_W;
        CODE_CTS_WR: op_raw = OP_CTS_W;
        default:     op_raw = OP_NONE;
      endcase
    end else if (type_i == TYPE_RD) begin
      unique case (code_i)
        CODE_LCR_RD: op_raw = OP_LCR_R;
        CODE_MSR_RD: op_raw = OP_MSR_R;
        default:     op_raw = OP_NONE;
      endcase
    end
  end

  assign need_len = (op_raw == OP_DIV_W) ? LEN_W'(DIV_BYTES) : LEN_W'(1);
  assign op_o     = (len_i == need_len) ? op_raw : OP_NONE;
  assign nbytes_o = (op_raw == OP_DIV_W) ? CNT_W'(DIV_BYTES) : CNT_W'(1);
endmodule

// File: rtl/vreq_payload.sv
module vreq_payload #(
  parameter int MAX_BYTES = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int WORD_W   = 8 * MAX_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic              busy_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W-1:0]  cnt_q, len_q, cnt_nx;
  logic [WORD_W-1:0] buf_q;
  logic              take;

  assign take   = byte_valid_i && busy_i && !start_i;
  assign cnt_nx = cnt_q + CNT_W'(1);
  assign done_o = take && (cnt_nx == len_q);

  // current byte merged into its little-endian lane
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    assign word_o[8*g +: 8] = (take && (cnt_q == CNT_W'(g))) ? byte_i : buf_q[8*g +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
      buf_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      len_q <= nbytes_i;
      buf_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_nx;
      buf_q <= word_o;
    end
  end
endmodule

// File: rtl/vreq_msr.sv
module vreq_msr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] lines_i,
  input  logic       clear_i,
  output logic [7:0] status_o
);
  // lines: [3] cd, [2] ri, [1] dsr, [0] cts
  logic [3:0] lines_q, delta_q, events;

  assign events[3] = lines_i[3] ^ lines_q[3];
  assign events[2] = lines_q[2] & ~lines_i[2];
  assign events[1] = lines_i[1] ^ lines_q[1];
  assign events[0] = lines_i[0] ^ lines_q[0];

  assign status_o = {lines_q, delta_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q <= '0;
      delta_q <= '0;
    end else begin
      lines_q <= lines_i;
      delta_q <= (clear_i ? 4'b0 : delta_q) | events;
    end
  end
endmodule

// File: rtl/vreq_decoder.sv
module vreq_decoder
  import vreq_pkg::*;
#(
  parameter int          LEN_W     = 16,
  parameter int          DIV_BYTES = 4,
  parameter logic [7:0]  LCR_RST   = 8'h03,
  parameter logic [7:0]  MCR_RST   = 8'h08,
  parameter int unsigned DIV_RST   = 12,
  localparam int CNT_W  = $clog2(DIV_BYTES + 1),
  localparam int DIV_W  = 8 * DIV_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_valid_i,
  input  logic [7:0]       req_type_i,
  input  logic [7:0]       req_code_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             data_valid_i,
  input  logic [7:0]       data_i,
  input  logic [3:0]       modem_i,
  output logic             ack_o,
  output logic             stall_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       lcr_o,
  output logic [7:0]       mcr_o,
  output logic [DIV_W-1:0] divisor_o,
  output logic             cts_hold_o,
  output logic             tx_enable_o
);
  op_e              dec_op, op_q;
  logic [CNT_W-1:0] dec_nbytes;
  logic             busy_q, start_wr, done;
  logic [DIV_W-1:0] word;
  logic [7:0]       msr_byte;
  logic             msr_clr;

  vreq_decode #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) u_decode (
    .type_i   (req_type_i),
    .code_i   (req_code_i),
    .len_i    (req_len_i),
    .op_o     (dec_op),
    .nbytes_o (dec_nbytes)
  );

  assign start_wr = setup_valid_i && op_is_write(dec_op);
  assign msr_clr  = setup_valid_i && (dec_op == OP_MSR_R);

  vreq_payload #(.MAX_BYTES(DIV_BYTES)) u_payload (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (setup_valid_i),
    .nbytes_i     (dec_nbytes),
    .busy_i       (busy_q),
    .byte_valid_i (data_valid_i),
    .byte_i       (data_i),
    .done_o       (done),
    .word_o       (word)
  );

  vreq_msr u_msr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (modem_i),
    .clear_i  (msr_clr),
    .status_o (msr_byte)
  );

  // a new setup always cancels a pending write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
    end else if (setup_valid_i) begin
      busy_q <= start_wr;
      op_q   <= start_wr ? dec_op : OP_NONE;
    end else if (done) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_o      <= LCR_RST;
      mcr_o      <= MCR_RST;
      divisor_o  <= DIV_W'(DIV_RST);
      cts_hold_o <= 1'b1;
    end else if (done) begin
      unique case (op_q)
        OP_DIV_W: divisor_o  <= word;
        OP_LCR_W: lcr_o      <= word[7:0];
        OP_MCR_W: mcr_o      <= word[7:0];
        OP_CTS_W: cts_hold_o <= |word[7:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      stall_o    <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      ack_o      <= 1'b0;
      stall_o    <= 1'b0;
      rd_valid_o <= 1'b0;
      if (setup_valid_i) begin
        unique case (dec_op)
          OP_NONE: stall_o <= 1'b1;
          OP_LCR_R: begin
            ack_o      <= 1'b1;
            rd_valid_o <= 1'b1;
            rd_data_o  <= lcr_o;
          end
          OP_MSR_R: begin
            ack_o      <= 1'b1;
            rd_valid_o <= 1'b1;
            rd_data_o  <= msr_byte;
          end
          default: ;
        endcase
      end else if (done) begin
        ack_o <= 1'b1;
      end
    end
  end

  assign tx_enable_o = !cts_hold_o || modem_i[0];
endmodule

// File: rtl/vreq_chk.sv
module vreq_chk #(
  parameter int DIV_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_o,
  input logic             stall_o,
  input logic             rd_valid_o,
  input logic [7:0]       lcr_o,
  input logic [7:0]       mcr_o,
  input logic [DIV_W-1:0] divisor_o,
  input logic             cts_hold_o
);
  // R2
  ack_stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_o, stall_o}));

  // R11
  rd_has_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ack_o);

  // R10
  stall_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ($stable(lcr_o) && $stable(mcr_o) && $stable(divisor_o) && $stable(cts_hold_o)));

  // R3
  div_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(divisor_o) |-> (ack_o && !rd_valid_o));

  // R5
  lcr_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lcr_o) |-> (ack_o && !rd_valid_o));

  // R6
  mcr_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mcr_o) |-> (ack_o && !rd_valid_o));

  // R8
  hold_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cts_hold_o) |-> (ack_o && !rd_valid_o));
endmodule

bind vreq_decoder vreq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .stall_o    (stall_o),
  .rd_valid_o (rd_valid_o),
  .lcr_o      (lcr_o),
  .mcr_o      (mcr_o),
  .divisor_o  (divisor_o),
  .cts_hold_o (cts_hold_o)
);

// File: tb/vreq_decoder_tb.sv
module vreq_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_valid = 1'b0;
  logic [7:0]  req_type = '0;
  logic [7:0]  req_code = '0;
  logic [15:0] req_len = '0;
  logic        data_valid = 1'b0;
  logic [7:0]  data = '0;
  logic [3:0]  modem = '0;
  logic        ack, stall, rd_valid, cts_hold, tx_en;
  logic [7:0]  rd_data, lcr, mcr;
  logic [31:0] divisor;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vreq_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .setup_valid_i(setup_valid),
    .req_type_i(req_type), .req_code_i(req_code), .req_len_i(req_len),
    .data_valid_i(data_valid), .data_i(data), .modem_i(modem),
    .ack_o(ack), .stall_o(stall), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .lcr_o(lcr), .mcr_o(mcr), .divisor_o(divisor),
    .cts_hold_o(cts_hold), .tx_enable_o(tx_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // drives a setup strobe from a negedge; returns at the negedge after it
  task automatic setup(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l);
    setup_valid = 1'b1;
    req_type = t; req_code = c; req_len = l;
    @(negedge clk);
    setup_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    data_valid = 1'b1;
    data = b;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic wr1(input logic [7:0] c, input logic [7:0] b, input string req);
    setup(8'h40, c, 16'd1);
    check({req, " no ack before payload"}, ack, 0);
    send(b);
    check({req, " ack on payload"}, {stall, ack}, 2'b01);
  endtask

  task automatic test_reset();
    check("R1 lcr", lcr, 8'h03);
    check("R1 mcr", mcr, 8'h08);
    check("R1 divisor", divisor, 32'd12);
    check("R1 cts hold", cts_hold, 1);
    check("R1 pulses", {ack, stall, rd_valid}, 3'b000);
    check("R8 tx blocked at reset", tx_en, 0);
  endtask

  task automatic test_lcr();
    wr1(8'd7, 8'h1B, "R5");
    check("R5 lcr written", lcr, 8'h1B);
    setup(8'hC0, 8'd6, 16'd1);
    check("R11 read pulses", {rd_valid, ack, stall}, 3'b110);
    check("R5 lcr readback", rd_data, 8'h1B);
    @(negedge clk);
    check("R11 read pulse one cycle", {rd_valid, ack}, 2'b00);
  endtask

  task automatic test_mcr();
    wr1(8'd10, 8'h0B, "R6");
    check("R6 mcr written", mcr, 8'h0B);
  endtask

  task automatic test_div();
    setup(8'h40, 8'd5, 16'd4);
    send(8'h80);
    send(8'h01);
    send(8'h00);
    check("R3 divisor held until last byte", divisor, 32'd12);
    send(8'h00);
    check("R3 ack with last byte", ack, 1);
    check("R3 divisor little-endian", divisor, 32'h0000_0180);
    setup(8'h40, 8'd5, 16'd4);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    check("R3 all four lanes", divisor, 32'h4433_2211);
  endtask

  task automatic test_abort();
    setup(8'h40, 8'd5, 16'd4);
    send(8'hAA);
    send(8'hBB);
    setup(8'h40, 8'd11, 16'd1);
    send(8'hCC);
    check("R4 aborting request acked", ack, 1);
    send(8'hDD);
    send(8'hEE);
    check("R4 divisor kept", divisor, 32'h4433_2211);
    check("R9 nop leaves lcr", lcr, 8'h1B);
    check("R9 nop leaves mcr", mcr, 8'h0B);
  endtask

  task automatic test_cts();
    wr1(8'd12, 8'h00, "R8");
    check("R8 hold cleared", cts_hold, 0);
    check("R8 tx allowed without cts", tx_en, 1);
    wr1(8'd12, 8'h01, "R8");
    check("R8 hold set", cts_hold, 1);
    check("R8 tx held without cts", tx_en, 0);
    modem = 4'b0001;
    #1;
    check("R8 tx allowed with cts", tx_en, 1);
    modem = 4'b0000;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bad(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l, input string req);
    setup(t, c, l);
    check(req, {stall, ack, rd_valid}, 3'b100);
    @(negedge clk);
    check({req, " stall one cycle"}, stall, 0);
  endtask

  task automatic test_bad();
    bad(8'h40, 8'd9, 16'd1, "R2 unknown write code");
    bad(8'h41, 8'd7, 16'd1, "R2 bad type");
    bad(8'hC0, 8'd7, 16'd1, "R2 write code as read");
    bad(8'h40, 8'd6, 16'd1, "R2 read code as write");
    bad(8'h40, 8'd7, 16'd2, "R10 lcr length 2");
    bad(8'h40, 8'd5, 16'd1, "R10 divisor length 1");
    bad(8'hC0, 8'd2, 16'd0, "R10 msr length 0");
    send(8'h55);
    check("R10 no ack after stall", ack, 0);
    check("R10 lcr unchanged", lcr, 8'h1B);
    check("R10 divisor unchanged", divisor, 32'h4433_2211);
  endtask

  task automatic test_idle();
    send(8'h77);
    check("R12 idle byte no ack", {ack, stall}, 2'b00);
    check("R12 idle byte lcr", lcr, 8'h1B);
    check("R12 idle byte mcr", mcr, 8'h0B);
    check("R12 idle byte hold", cts_hold, 1);
  endtask

  task automatic rd_msr(input logic [7:0] exp, input string req);
    setup(8'hC0, 8'd2, 16'd1);
    check({req, " valid"}, {rd_valid, ack}, 2'b11);
    check(req, rd_data, exp);
  endtask

  task automatic test_msr();
    rd_msr(8'h00, "R7 quiet");
    modem = 4'b0001;
    @(negedge clk); @(negedge clk);
    rd_msr(8'h11, "R7 cts rose");
    rd_msr(8'h10, "R7 cleared on read");
    modem = 4'b0101;
    @(negedge clk); @(negedge clk);
    rd_msr(8'h50, "R7 ri rise no flag");
    modem = 4'b0001;
    @(negedge clk); @(negedge clk);
    rd_msr(8'h14, "R7 ri fell");
    modem = 4'b1011;
    @(negedge clk); @(negedge clk);
    rd_msr(8'hB0 | 8'h0A, "R7 cd and dsr changed");
    modem = 4'b0000;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_lcr();
    test_mcr();
    test_div();
    test_abort();
    test_cts();
    test_bad();
    test_idle();
    test_msr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule